// File: doc/BRIEF.md
# Inner Edge Deblocking Filter

This block smooths blocking artefacts across one vertical boundary between two pixel blocks. A job covers a column of eight rows. Each row delivers eight unsigned pixels, four on the left of the boundary and four on the right. With each row come three thresholds: a boundary limit, an interior limit and a variance limit. The block decides per row whether the boundary looks like a coding artefact or like real image content. It then rewrites two or four pixels next to the boundary, or none. The result comes back as the full row with one write-enable bit per pixel position.

Rows enter through a valid/ready handshake and are processed in a two-stage pipeline. When the consumer never stalls, one row is accepted per clock. Each output row carries its index within the edge and a flag that marks the eighth row. The caller is expected to hold the thresholds fixed across the eight rows of an edge. The block filters each row on its own and keeps no state between rows beyond the row index.

Top module: `dbf_edge_filter`

## Requirements
- R1: While reset is high and in the cycle after it falls, `out_valid` is low and `in_ready` is high. The first accepted row after reset is reported as row 0.
- R2: A row passes the filter mask only when two conditions hold. Each of the six neighbour differences |L3−L2|, |L2−L1|, |L1−L0|, |R1−R0|, |R2−R1|, |R3−R2| must be ≤ the interior limit. Also 2·|L0−R0| + (|L1−R1|>>1) must be ≤ the boundary limit. When the mask fails, `out_we` is 0 and `out_pix` equals the input row.
- R3: High variance holds when |L1−L0| > the variance limit or |R1−R0| > the variance limit. A masked row with high variance gets `out_we` = 8'h18, which rewrites L0 and R0 only.
- R4: A masked row without high variance gets `out_we` = 8'h3C, which rewrites L1, L0, R0 and R1.
- R5: Pixels are biased to signed form by subtracting 128. Then t = hev ? sat(L1−R1) : 0 and a = sat(t + 3·(R0−L0)). Next f1 = sat(a+4)>>3 and f2 = sat(a+3)>>3, both arithmetic shifts. New R0 = sat(R0−f1) and new L0 = sat(L0+f2). Without high variance, also g = (f1+1)>>1, new R1 = sat(R1−g) and new L1 = sat(L1+g). Here sat() limits to −128..127, and 128 is added back to each result.
- R6: Every intermediate and every output value saturates, so no output wraps outside 0..255.
- R7: Positions whose write-enable bit is low return the input pixel unchanged, including L3, L2, R2 and R3 in every row.
- R8: `out_row` counts accepted rows 0..7 and wraps. `out_last` is high exactly when a valid output has `out_row` = 7.
- R9: With `out_ready` held high, a row accepted in cycle c appears on the outputs in cycle c+2, and back-to-back rows leave on consecutive cycles.
- R10: While `out_valid` is high and `out_ready` is low, the outputs hold their values and `in_ready` is low.
- R11: The mask and interior comparisons are inclusive and the variance comparison is strict: a difference equal to a limit passes the mask and does not raise high variance.

Pixel slot k occupies `in_pix[8k+7:8k]`, and `out_we[k]` covers the same slot. Slots 0..3 are L3, L2, L1, L0 and slots 4..7 are R0, R1, R2, R3. The boundary lies between slots 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A row is offered |
| in_ready | output | 1 | The row is accepted on this edge |
| in_pix | input | 64 | Eight pixels, slot 0 (L3) in the low byte |
| thr_e | input | 8 | Boundary limit |
| thr_i | input | 8 | Interior limit |
| thr_h | input | 8 | Variance limit |
| out_valid | output | 1 | A filtered row is presented |
| out_ready | input | 1 | Consumer takes the row |
| out_pix | output | 64 | Filtered row, same slot order |
| out_we | output | 8 | Per-slot write enables |
| out_row | output | 3 | Row index within the edge |
| out_last | output | 1 | High with the eighth row of an edge |

## Verification
On every cycle the assertions check that the write-enable pattern is one of the three legal shapes. They also check that a stalled output holds still and blocks the input, and that consecutive delivered rows carry consecutive indices. Only the bench scenarios can show the filter values themselves. That covers the exact mask and variance thresholds at their boundaries, saturation of the outer taps, pass-through of untouched pixels, and the two-cycle latency with one row per clock.

// File: rtl/dbf_pkg.sv
`timescale 1ns/1ps
package dbf_pkg;
  localparam int NTAP = 8;
  localparam int IL3 = 0, IL2 = 1, IL1 = 2, IL0 = 3;
  localparam int IR0 = 4, IR1 = 5, IR2 = 6, IR3 = 7;
  localparam logic [NTAP-1:0] WE_NONE   = 8'b0000_0000;
  localparam logic [NTAP-1:0] WE_NARROW = 8'b0001_1000;
  localparam logic [NTAP-1:0] WE_WIDE   = 8'b0011_1100;
endpackage

// File: rtl/dbf_decide.sv
`timescale 1ns/1ps
// Per-row decisions: filter mask and high-variance flag.
module dbf_decide
  import dbf_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int TH_W  = 8
) (
  input  logic [PIX_W-1:0] pix [NTAP],
  input  logic [TH_W-1:0]  thr_e,
  input  logic [TH_W-1:0]  thr_i,
  input  logic [TH_W-1:0]  thr_h,
  output logic             mask,
  output logic             hev
);
  localparam int CW = ((PIX_W + 2 > TH_W) ? PIX_W + 2 : TH_W) + 1;

  function automatic logic [CW-1:0] adiff(input logic [PIX_W-1:0] a, input logic [PIX_W-1:0] b);
    return (a > b) ? CW'(a - b) : CW'(b - a);
  endfunction

  logic [CW-1:0] lim_e, lim_i, lim_h, edge_sum;
  logic [5:0]    in_ok;

  assign lim_e = CW'(thr_e);
  assign lim_i = CW'(thr_i);
  assign lim_h = CW'(thr_h);

  // Interior flatness: three neighbour pairs on each side, mirrored.
  for (genvar k = 0; k < 3; k++) begin : g_side
    assign in_ok[k]     = adiff(pix[k], pix[k+1]) <= lim_i;
    assign in_ok[3 + k] = adiff(pix[NTAP-1-k], pix[NTAP-2-k]) <= lim_i;
  end

  assign edge_sum = (adiff(pix[IL0], pix[IR0]) << 1) + (adiff(pix[IL1], pix[IR1]) >> 1);
  assign mask     = (&in_ok) && (edge_sum <= lim_e);
  assign hev      = (adiff(pix[IL1], pix[IL0]) > lim_h) || (adiff(pix[IR1], pix[IR0]) > lim_h);
endmodule

// File: rtl/dbf_core.sv
`timescale 1ns/1ps
// Signed-domain 4-tap filter arithmetic for one row.
module dbf_core
  import dbf_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] pix  [NTAP],
  input  logic             mask,
  input  logic             hev,
  output logic [PIX_W-1:0] npix [NTAP],
  output logic [NTAP-1:0]  we
);
  localparam int SW   = PIX_W + 4;
  localparam int BIAS = 1 << (PIX_W - 1);
  localparam logic signed [SW-1:0] SMAX = SW'(BIAS - 1);
  localparam logic signed [SW-1:0] SMIN = ~SMAX;

  function automatic logic signed [SW-1:0] sat(input logic signed [SW-1:0] v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  function automatic logic signed [SW-1:0] to_s(input logic [PIX_W-1:0] p);
    return $signed({{(SW-PIX_W){1'b0}}, p}) - SW'(BIAS);
  endfunction

  function automatic logic [PIX_W-1:0] to_u(input logic signed [SW-1:0] v);
    logic signed [SW-1:0] t;
    t = v + SW'(BIAS);
    return t[PIX_W-1:0];
  endfunction

  logic signed [SW-1:0] sl1, sl0, sr0, sr1, base, dif, acc, f1, f2, g;

  always_comb begin
    sl1  = to_s(pix[IL1]);
    sl0  = to_s(pix[IL0]);
    sr0  = to_s(pix[IR0]);
    sr1  = to_s(pix[IR1]);
    base = hev ? sat(sl1 - sr1) : '0;
    dif  = sr0 - sl0;
    acc  = sat(base + dif + dif + dif);
    f1   = sat(acc + SW'(4)) >>> 3;
    f2   = sat(acc + SW'(3)) >>> 3;
    g    = (f1 + SW'(1)) >>> 1;
    npix = pix;
    we   = WE_NONE;
    if (mask) begin
      npix[IR0] = to_u(sat(sr0 - f1));
      npix[IL0] = to_u(sat(sl0 + f2));
      we        = WE_NARROW;
      if (!hev) begin
        npix[IR1] = to_u(sat(sr1 - g));
        npix[IL1] = to_u(sat(sl1 + g));
        we        = WE_WIDE;
      end
    end
  end
endmodule

// File: rtl/dbf_edge_filter.sv
`timescale 1ns/1ps
// Two-stage row pipeline: decide, then filter; global stall on output backpressure.
module dbf_edge_filter
  import dbf_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int TH_W  = 8,
  parameter int ROWS  = 8,
  localparam int RW   = $clog2(ROWS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [NTAP*PIX_W-1:0] in_pix,
  input  logic [TH_W-1:0]       thr_e,
  input  logic [TH_W-1:0]       thr_i,
  input  logic [TH_W-1:0]       thr_h,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [NTAP*PIX_W-1:0] out_pix,
  output logic [NTAP-1:0]       out_we,
  output logic [RW-1:0]         out_row,
  output logic                  out_last
);
  logic             adv;
  logic [PIX_W-1:0] in_arr [NTAP];
  logic [PIX_W-1:0] a_pix  [NTAP];
  logic [PIX_W-1:0] f_pix  [NTAP];
  logic [NTAP-1:0]  f_we;
  logic             mask_c, hev_c, a_vld, a_mask, a_hev;
  logic [RW-1:0]    row_cnt, a_row;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  for (genvar k = 0; k < NTAP; k++) begin : g_unpack
    assign in_arr[k] = in_pix[k*PIX_W +: PIX_W];
  end

  dbf_decide #(.PIX_W(PIX_W), .TH_W(TH_W)) u_dec (
    .pix(in_arr), .thr_e(thr_e), .thr_i(thr_i), .thr_h(thr_h),
    .mask(mask_c), .hev(hev_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_vld     <= 1'b0;
      out_valid <= 1'b0;
      row_cnt   <= '0;
    end else if (adv) begin
      a_vld     <= in_valid;
      out_valid <= a_vld;
      if (in_valid) row_cnt <= (row_cnt == RW'(ROWS - 1)) ? '0 : row_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (adv && in_valid) begin
      a_pix  <= in_arr;
      a_mask <= mask_c;
      a_hev  <= hev_c;
      a_row  <= row_cnt;
    end
  end

  dbf_core #(.PIX_W(PIX_W)) u_core (
    .pix(a_pix), .mask(a_mask), .hev(a_hev), .npix(f_pix), .we(f_we)
  );

  always_ff @(posedge clk) begin
    if (adv && a_vld) begin
      for (int k = 0; k < NTAP; k++) out_pix[k*PIX_W +: PIX_W] <= f_pix[k];
      out_we  <= f_we;
      out_row <= a_row;
    end
  end

  assign out_last = out_valid && (out_row == RW'(ROWS - 1));

  // R3 / R4 / R2: only three write-enable shapes ever leave the block
  assert_we_shape_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_we == WE_NONE || out_we == WE_NARROW || out_we == WE_WIDE));

  // R10: a stalled row stays put
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) && $stable(out_we) && $stable(out_row)));

  // R10: input is blocked while the output stalls
  assert_block_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R8: the row delivered after a taken row carries the next index
  assert_row_step_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> (!out_valid ||
      out_row == (($past(out_row) == RW'(ROWS - 1)) ? '0 : $past(out_row) + 1'b1)));
endmodule

// File: tb/sim_dbf_edge_filter.sv
`timescale 1ns/1ps
module sim_dbf_edge_filter;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, out_valid, out_ready, out_last;
  logic [63:0] in_pix, out_pix;
  logic [7:0]  thr_e, thr_i, thr_h, out_we;
  logic [2:0]  out_row;

  always #2.5 clk = ~clk;

  dbf_edge_filter #(.PIX_W(8), .TH_W(8), .ROWS(8)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .thr_e(thr_e), .thr_i(thr_i), .thr_h(thr_h), .out_valid(out_valid), .out_ready(out_ready),
    .out_pix(out_pix), .out_we(out_we), .out_row(out_row), .out_last(out_last)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, sent = 0, acc_stamp = 0;
  bit finished = 0;
  logic [63:0] q_pix[$];
  logic [7:0]  q_we[$];
  int          q_row[$];
  string       q_tag[$];
  int          out_stamp[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input int l3, l2, l1, l0, r0, r1, r2, r3);
    return {8'(r3), 8'(r2), 8'(r1), 8'(r0), 8'(l0), 8'(l1), 8'(l2), 8'(l3)};
  endfunction

  function automatic int ad(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  function automatic int c8(input int x);
    return (x < -128) ? -128 : (x > 127) ? 127 : x;
  endfunction

  // Reference computed from R2..R7
  function automatic void model(input logic [63:0] r, input int e, input int i, input int h,
                                output logic [63:0] o, output logic [7:0] we);
    int v[8];
    int s1, s0, t0, t1, a, f1, f2, g;
    bit m, hv;
    for (int k = 0; k < 8; k++) v[k] = int'(r[k*8 +: 8]);
    m  = ad(v[0], v[1]) <= i && ad(v[1], v[2]) <= i && ad(v[2], v[3]) <= i &&
         ad(v[5], v[4]) <= i && ad(v[6], v[5]) <= i && ad(v[7], v[6]) <= i &&
         (ad(v[3], v[4]) * 2 + ad(v[2], v[5]) / 2) <= e;
    hv = ad(v[2], v[3]) > h || ad(v[5], v[4]) > h;
    o  = r;
    we = 8'h00;
    if (m) begin
      s1 = v[2] - 128; s0 = v[3] - 128; t0 = v[4] - 128; t1 = v[5] - 128;
      a  = hv ? c8(s1 - t1) : 0;
      a  = c8(a + 3 * (t0 - s0));
      f1 = c8(a + 4) >>> 3;
      f2 = c8(a + 3) >>> 3;
      o[32 +: 8] = 8'(c8(t0 - f1) + 128);
      o[24 +: 8] = 8'(c8(s0 + f2) + 128);
      if (hv) we = 8'h18;
      else begin
        g  = (f1 + 1) >>> 1;
        o[40 +: 8] = 8'(c8(t1 - g) + 128);
        o[16 +: 8] = 8'(c8(s1 + g) + 128);
        we = 8'h3C;
      end
    end
  endfunction

  task automatic send(input logic [63:0] r, input int e, input int i, input int h,
                      input logic [63:0] eo, input logic [7:0] ew, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_pix = r; thr_e = 8'(e); thr_i = 8'(i); thr_h = 8'(h);
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    acc_stamp = cyc;
    q_pix.push_back(eo); q_we.push_back(ew); q_row.push_back(sent % 8); q_tag.push_back(tag);
    sent++;
    @(posedge clk);
    #0.5 in_valid = 1'b0;
  endtask

  task automatic send_m(input logic [63:0] r, input int e, input int i, input int h, input string tag);
    logic [63:0] eo;
    logic [7:0]  ew;
    model(r, e, i, h, eo, ew);
    send(r, e, i, h, eo, ew, tag);
  endtask

  task automatic drain();
    for (int k = 0; k < 60 && q_pix.size() > 0; k++) @(negedge clk);
    chk(q_pix.size() == 0, "R9 drain", 64'(q_pix.size()), 64'd0);
  endtask

  // Collector: compares every delivered row
  initial begin
    forever begin
      @(negedge clk); #1;
      if (!rst && out_valid && out_ready) begin
        if (q_pix.size() == 0) chk(1'b0, "R9 unexpected row", out_pix, 64'd0);
        else begin
          logic [63:0] ep; logic [7:0] ew; int er; string tg;
          ep = q_pix.pop_front(); ew = q_we.pop_front(); er = q_row.pop_front(); tg = q_tag.pop_front();
          chk(out_pix == ep, {tg, " pixels"}, out_pix, ep);
          chk(out_we == ew, {tg, " write-enables"}, 64'(out_we), 64'(ew));
          chk(int'(out_row) == er && out_last == (er == 7), "R8 row index/last",
              {out_last, 60'(out_row)}, {(er == 7), 60'(er)});
          out_stamp.push_back(cyc);
        end
      end
    end
  end

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1; in_pix = '0; thr_e = 0; thr_i = 0; thr_h = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 during reset", {out_valid, in_ready}, 64'b01);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 after reset", {out_valid, in_ready}, 64'b01);
  endtask

  task automatic t_flat();   // R4 R7: flat row, wide pattern, values unchanged
    send(mk(100,100,100,100,100,100,100,100), 10, 10, 5,
         mk(100,100,100,100,100,100,100,100), 8'h3C, "R4 flat");
    drain();
  endtask

  task automatic t_step();   // R5 arithmetic on a small step
    send(mk(100,100,100,100,104,104,104,104), 20, 10, 5,
         mk(100,100,101,101,102,103,104,104), 8'h3C, "R5 step");
    drain();
  endtask

  task automatic t_skip();   // R2 R7: mask fails, row returned untouched
    send(mk(100,100,100,100,150,150,150,150), 20, 10, 5,
         mk(100,100,100,100,150,150,150,150), 8'h00, "R2 skip");
    drain();
  endtask

  task automatic t_hev();    // R3: only L0 and R0 rewritten
    send(mk(120,120,120,100,110,110,110,110), 60, 30, 5,
         mk(120,120,120,105,105,110,110,110), 8'h18, "R3 hev");
    drain();
  endtask

  task automatic t_clip();   // R6: outer tap saturates at 0
    send(mk(0,0,0,0,127,0,0,0), 255, 255, 255,
         mk(0,0,8,15,112,0,0,0), 8'h3C, "R6 saturate");
    drain();
  endtask

  task automatic t_bound();  // R11: equality at every limit
    send(mk(103,103,103,100,104,104,104,104), 8, 3, 3,
         mk(103,103,104,101,102,103,104,104), 8'h3C, "R11 all equal");
    send(mk(103,103,103,100,104,104,104,104), 7, 3, 3,
         mk(103,103,103,100,104,104,104,104), 8'h00, "R11 edge limit-1");
    send(mk(103,103,103,100,104,104,104,104), 8, 2, 3,
         mk(103,103,103,100,104,104,104,104), 8'h00, "R11 interior limit-1");
    send(mk(103,103,103,100,104,104,104,104), 8, 3, 2,
         mk(103,103,103,101,103,104,104,104), 8'h18, "R11 variance limit-1");
    drain();
  endtask

  task automatic t_stream(); // R9 R8: 8 rows back to back, then mixed random rows
    int first_acc, e, i, h, b;
    int p[8];
    out_stamp.delete();
    first_acc = 0;
    for (int n = 0; n < 32; n++) begin
      if (n % 8 == 0) begin
        e = $urandom_range(255); i = $urandom_range(40); h = $urandom_range(20);
      end
      b = $urandom_range(255);
      for (int k = 0; k < 8; k++) begin
        p[k] = (n % 5 == 4) ? int'($urandom_range(255)) : b + int'($urandom_range(24)) - 12;
        if (p[k] < 0) p[k] = 0;
        if (p[k] > 255) p[k] = 255;
      end
      send_m(mk(p[0],p[1],p[2],p[3],p[4],p[5],p[6],p[7]), e, i, h, "R5 random");
      if (n == 0) first_acc = acc_stamp;
    end
    drain();
    chk(out_stamp.size() == 32, "R9 row count", 64'(out_stamp.size()), 64'd32);
    if (out_stamp.size() == 32) begin
      chk(out_stamp[0] - first_acc == 2, "R9 latency", 64'(out_stamp[0] - first_acc), 64'd2);
      chk(out_stamp[31] - out_stamp[0] == 31, "R9 one row per cycle",
          64'(out_stamp[31] - out_stamp[0]), 64'd31);
    end
  endtask

  task automatic t_stall();  // R10: output held, input blocked
    logic [63:0] held;
    @(negedge clk); out_ready = 1'b0;
    send(mk(100,100,100,100,104,104,104,104), 20, 10, 5,
         mk(100,100,101,101,102,103,104,104), 8'h3C, "R10 after stall");
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b1 && in_ready == 1'b0, "R10 stalled flags", {out_valid, in_ready}, 64'b10);
    held = out_pix;
    repeat (3) @(negedge clk);
    #1;
    chk(out_pix == held && out_valid == 1'b1, "R10 hold", out_pix, held);
    @(negedge clk); out_ready = 1'b1;
    drain();
  endtask

  initial begin
    t_reset();
    t_flat();
    t_step();
    t_skip();
    t_hev();
    t_clip();
    t_bound();
    t_stall();
    t_stream();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule